// File: doc/BRIEF.md
# Byte String Move and Translate Engine

This engine works on 8-bit characters held two to a 16-bit memory word, with a byte pointer selecting one character. It runs one of three string operations on a start strobe. Forward move and reverse move copy a counted run of characters from a source pointer to a destination pointer. Translate rewrites a string in place: each character indexes a byte table located at the second pointer, and the table byte replaces it. Translate stops at a terminator key.

A caller loads the pointers, the 8-bit count, the key and the mode, and pulses start. The engine then owns a single word-wide memory port. Each character costs three cycles: read the source word, read the destination or table word, and write back a merged word. When the run ends, done pulses for one cycle. The final pointers and an exit code are valid on that cycle, so the caller can chain the next step from them.

Top module: `strmv_top`

## Requirements
- R1: After reset, busy_o, done_o and mem_req_o are 0 and exit_o is 0.
- R2: Mode 0 (forward move) copies the character at source+i to destination+i for i = 0..n-1. At done, src_ptr_o = source+n, dst_ptr_o = destination+n and exit_o = 1.
- R3: Mode 1 (reverse move) copies the character at source-i to destination-i for i = 0..n-1. At done, src_ptr_o = source-n, dst_ptr_o = destination-n and exit_o = 1.
- R4: The move length n is (count_i + 1) mod 256, with 0 read as 256: a count of 0 moves one character and a count of 255 moves 256.
- R5: A character at an even byte address lives in bits 7:0 of word address/2, and one at an odd address lives in bits 15:8. Every character write leaves the other byte of its word unchanged.
- R6: Mode 2 (translate) replaces the character c at the data pointer with the byte at byte address (table base + c), then advances the data pointer by one. The table pointer dst_ptr_o stays equal to the base.
- R7: Translate ends at the first data character equal to key_i. That character is not rewritten, src_ptr_o addresses it, and exit_o = 2.
- R8: done_o is high for exactly one cycle. busy_o is high from the cycle after start until done, and both are low the cycle after done.
- R9: Mode 3 is a no-op: done_o rises in the cycle after start with exit_o = 0 and unchanged pointers, and no memory access is made.
- R10: Read data is taken one cycle after a read request. A write is only issued together with a request, and no request is issued while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| mode_i | input | 2 | 0 forward move, 1 reverse move, 2 translate, 3 no-op |
| src_ptr_i | input | 16 | Source / data string byte pointer |
| dst_ptr_i | input | 16 | Destination byte pointer or table base |
| count_i | input | 8 | Move length minus one |
| key_i | input | 8 | Translate terminator |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable (full word) |
| mem_addr_o | output | 15 | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, one cycle after a read request |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| exit_o | output | 2 | 1 run complete, 2 key found, 0 no-op; valid with done |
| src_ptr_o | output | 16 | Current source / data pointer |
| dst_ptr_o | output | 16 | Current destination pointer or table base |

## Verification
The in-line properties check several things on every cycle. done never lasts two cycles, and the exit code always matches the mode that produced it. The number of writes in a move equals count+1, including the 256-character case. The memory port stays quiet while idle, and a write never appears without a request.

Other behaviours only the bench scenarios can show, by comparing every written word against a shadow byte model. These are the data values themselves: byte-lane merging at odd and even alignments, reverse ordering, table lookups, the untouched terminator and the final pointer values.

// File: rtl/strmv_pkg.sv
package strmv_pkg;
  typedef enum logic [1:0] {
    MODE_MOVE_FWD = 2'd0,
    MODE_MOVE_REV = 2'd1,
    MODE_XLATE    = 2'd2,
    MODE_NOP      = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    EXIT_NONE = 2'd0,
    EXIT_DONE = 2'd1,
    EXIT_KEY  = 2'd2
  } exit_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSRC,
    ST_RDST,
    ST_WR,
    ST_FIN
  } state_e;
endpackage

// File: rtl/strmv_pick.sv
module strmv_pick #(
  parameter int DW = 16,
  parameter int CW = 8,
  localparam int NB = DW / CW,
  localparam int LB = $clog2(NB)
) (
  input  logic [DW-1:0] word_i,
  input  logic [LB-1:0] sel_i,
  output logic [CW-1:0] char_o
);
  always_comb begin
    char_o = '0;
    for (int b = 0; b < NB; b++) begin
      if (sel_i == LB'(b)) char_o = word_i[b*CW +: CW];
    end
  end
endmodule

// File: rtl/strmv_merge.sv
module strmv_merge #(
  parameter int DW = 16,
  parameter int CW = 8,
  localparam int NB = DW / CW,
  localparam int LB = $clog2(NB)
) (
  input  logic [DW-1:0] word_i,
  input  logic [LB-1:0] sel_i,
  input  logic [CW-1:0] char_i,
  output logic [DW-1:0] word_o
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign word_o[g*CW +: CW] = (sel_i == LB'(g)) ? char_i : word_i[g*CW +: CW];
  end
endmodule

// File: rtl/strmv_ptr_unit.sv
module strmv_ptr_unit #(
  parameter int PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [PW-1:0] src_i,
  input  logic [PW-1:0] dst_i,
  input  logic          step_i,
  input  logic          step_dst_i,
  input  logic          rev_i,
  output logic [PW-1:0] src_o,
  output logic [PW-1:0] dst_o
);
  logic [PW-1:0] src_q, dst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (load_i) begin
      src_q <= src_i;
      dst_q <= dst_i;
    end else if (step_i) begin
      src_q <= rev_i ? src_q - PW'(1) : src_q + PW'(1);
      if (step_dst_i) dst_q <= rev_i ? dst_q - PW'(1) : dst_q + PW'(1);
    end
  end

  assign src_o = src_q;
  assign dst_o = dst_q;
endmodule

// File: rtl/strmv_fsm.sv
module strmv_fsm
  import strmv_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] key_i,
  input  logic [CW-1:0] char_i,
  input  logic [DW-1:0] word_i,
  output state_e        state_o,
  output logic          xlate_o,
  output logic          rev_o,
  output logic          load_o,
  output logic          step_o,
  output logic          step_dst_o,
  output logic          req_o,
  output logic          we_o,
  output logic          done_o,
  output logic [1:0]    exit_o,
  output logic [CW-1:0] ch_o,
  output logic [DW-1:0] word_o
);
  state_e        state_q;
  mode_e         mode_q;
  exit_e         exit_q;
  logic [CW:0]   remain_q;
  logic [CW-1:0] key_q, ch_q;
  logic [DW-1:0] word_q;
  logic          stop_hit;

  assign stop_hit = (mode_q == MODE_XLATE) && (char_i == key_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      mode_q   <= MODE_MOVE_FWD;
      exit_q   <= EXIT_NONE;
      remain_q <= '0;
      key_q    <= '0;
      ch_q     <= '0;
      word_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q   <= mode_e'(mode_i);
          key_q    <= key_i;
          exit_q   <= EXIT_NONE;
          remain_q <= {1'b0, count_i} + (CW+1)'(1);
          state_q  <= (mode_e'(mode_i) == MODE_NOP) ? ST_FIN : ST_RSRC;
        end
        ST_RSRC: state_q <= ST_RDST;
        ST_RDST: begin
          ch_q   <= char_i;
          word_q <= word_i;
          if (stop_hit) begin
            exit_q  <= EXIT_KEY;
            state_q <= ST_FIN;
          end else begin
            state_q <= ST_WR;
          end
        end
        ST_WR: begin
          if (mode_q == MODE_XLATE) begin
            state_q <= ST_RSRC;
          end else begin
            remain_q <= remain_q - (CW+1)'(1);
            if (remain_q == (CW+1)'(1)) begin
              exit_q  <= EXIT_DONE;
              state_q <= ST_FIN;
            end else begin
              state_q <= ST_RSRC;
            end
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o    = state_q;
  assign xlate_o    = (mode_q == MODE_XLATE);
  assign rev_o      = (mode_q == MODE_MOVE_REV);
  assign load_o     = (state_q == ST_IDLE) && start_i;
  assign step_o     = (state_q == ST_WR);
  assign step_dst_o = (mode_q != MODE_XLATE);
  assign req_o      = (state_q == ST_RSRC) || (state_q == ST_WR) ||
                      ((state_q == ST_RDST) && !stop_hit);
  assign we_o       = (state_q == ST_WR);
  assign done_o     = (state_q == ST_FIN);
  assign exit_o     = done_o ? exit_q : EXIT_NONE;
  assign ch_o       = ch_q;
  assign word_o     = word_q;

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_key_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && exit_o == EXIT_KEY) |-> (mode_q == MODE_XLATE));
  assert_nop_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_q == MODE_NOP) |-> (exit_o == EXIT_NONE));
  assert_move_exit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (mode_q == MODE_MOVE_FWD || mode_q == MODE_MOVE_REV)) |-> (exit_o == EXIT_DONE));
endmodule

// File: rtl/strmv_top.sv
module strmv_top
  import strmv_pkg::*;
#(
  parameter int PW = 16,
  parameter int DW = 16,
  parameter int CW = 8,
  localparam int NB = DW / CW,
  localparam int LB = $clog2(NB),
  localparam int AW = PW - LB
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic [PW-1:0] src_ptr_i,
  input  logic [PW-1:0] dst_ptr_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] key_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    exit_o,
  output logic [PW-1:0] src_ptr_o,
  output logic [PW-1:0] dst_ptr_o
);
  state_e        state;
  logic          xlate, rev, load, step, step_dst;
  logic [CW-1:0] src_char, ch_q, wr_char;
  logic [DW-1:0] word_q, move_word, xlate_word;
  logic [PW-1:0] src_q, dst_q, tbl_ptr;
  logic [LB-1:0] wr_sel;

  strmv_fsm #(.DW(DW), .CW(CW)) u_fsm (
    .clk_i, .rst_ni, .start_i, .mode_i, .count_i, .key_i,
    .char_i(src_char), .word_i(mem_rdata_i),
    .state_o(state), .xlate_o(xlate), .rev_o(rev), .load_o(load),
    .step_o(step), .step_dst_o(step_dst), .req_o(mem_req_o), .we_o(mem_we_o),
    .done_o, .exit_o, .ch_o(ch_q), .word_o(word_q)
  );

  strmv_ptr_unit #(.PW(PW)) u_ptr (
    .clk_i, .rst_ni, .load_i(load), .src_i(src_ptr_i), .dst_i(dst_ptr_i),
    .step_i(step), .step_dst_i(step_dst), .rev_i(rev),
    .src_o(src_q), .dst_o(dst_q)
  );

  // table entry address: live char while issuing the read, held char while writing
  assign tbl_ptr = dst_q + PW'((state == ST_WR) ? ch_q : src_char);
  assign wr_sel  = xlate ? tbl_ptr[LB-1:0] : dst_q[LB-1:0];

  strmv_pick  #(.DW(DW), .CW(CW)) u_pick_src (
    .word_i(mem_rdata_i), .sel_i(src_q[LB-1:0]), .char_o(src_char));
  strmv_pick  #(.DW(DW), .CW(CW)) u_pick_tbl (
    .word_i(mem_rdata_i), .sel_i(wr_sel), .char_o(wr_char));
  strmv_merge #(.DW(DW), .CW(CW)) u_merge_dst (
    .word_i(mem_rdata_i), .sel_i(wr_sel), .char_i(ch_q), .word_o(move_word));
  strmv_merge #(.DW(DW), .CW(CW)) u_merge_src (
    .word_i(word_q), .sel_i(src_q[LB-1:0]), .char_i(wr_char), .word_o(xlate_word));

  always_comb begin
    unique case (state)
      ST_RDST: mem_addr_o = xlate ? tbl_ptr[PW-1:LB] : dst_q[PW-1:LB];
      ST_WR:   mem_addr_o = xlate ? src_q[PW-1:LB]   : dst_q[PW-1:LB];
      default: mem_addr_o = src_q[PW-1:LB];
    endcase
  end

  assign mem_wdata_o = xlate ? xlate_word : move_word;
  assign busy_o      = (state != ST_IDLE);
  assign src_ptr_o   = src_q;
  assign dst_ptr_o   = dst_q;

  // independent write tally for the move-length check
  logic [CW:0] chk_wr_q, chk_len_q;
  logic        chk_move_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_wr_q   <= '0;
      chk_len_q  <= '0;
      chk_move_q <= 1'b0;
    end else if (start_i && !busy_o) begin
      chk_wr_q   <= '0;
      chk_len_q  <= {1'b0, count_i} + (CW+1)'(1);
      chk_move_q <= (mode_i == MODE_MOVE_FWD) || (mode_i == MODE_MOVE_REV);
    end else if (mem_we_o) begin
      chk_wr_q <= chk_wr_q + (CW+1)'(1);
    end
  end

  assert_move_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && chk_move_q) |-> (chk_wr_q == chk_len_q));
  assert_we_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o);
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
endmodule

// File: tb/strmv_top_tb.sv
module strmv_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = '0;
  logic [15:0] src_ptr = '0, dst_ptr = '0;
  logic [7:0]  count = '0, key = '0;
  logic        mem_req, mem_we, busy, done;
  logic [14:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [1:0]  exit_code;
  logic [15:0] src_out, dst_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  strmv_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .src_ptr_i(src_ptr), .dst_ptr_i(dst_ptr), .count_i(count), .key_i(key),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .busy_o(busy),
    .done_o(done), .exit_o(exit_code), .src_ptr_o(src_out), .dst_ptr_o(dst_out)
  );

  logic [15:0] mem [256];
  logic [15:0] sh  [256];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  typedef struct packed { logic [7:0] a; logic [15:0] d; } wr_t;
  wr_t exp_q[$];
  int  n_run = 0, n_fail = 0;
  logic [1:0]  exp_exit;
  logic [15:0] exp_src, exp_dst;
  logic        done_seen = 1'b0;
  string       cur_req = "R2";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] getb(input logic [15:0] a);
    return a[0] ? sh[a[8:1]][15:8] : sh[a[8:1]][7:0];
  endfunction

  // shadow byte write (R5 lane rule), expected word pushed for the monitor
  task automatic setb(input logic [15:0] a, input logic [7:0] b);
    if (a[0]) sh[a[8:1]][15:8] = b;
    else      sh[a[8:1]][7:0]  = b;
    exp_q.push_back('{a: a[8:1], d: sh[a[8:1]]});
  endtask

  // monitor: scoreboard pops on every write, compares completion on done
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected write", {17'd0, mem_addr}, 32'hffff);
      end else begin
        automatic wr_t e = exp_q.pop_front();
        chk(mem_addr[7:0] == e.a, cur_req, "write addr", {24'd0, mem_addr[7:0]}, {24'd0, e.a});
        chk(mem_wdata == e.d, cur_req, "write data R5", {16'd0, mem_wdata}, {16'd0, e.d});
      end
    end
    if (rst_n && done) begin
      done_seen = 1'b1;
      chk(exit_code == exp_exit, cur_req, "exit code", {30'd0, exit_code}, {30'd0, exp_exit});
      chk(src_out == exp_src, cur_req, "final src ptr", {16'd0, src_out}, {16'd0, exp_src});
      chk(dst_out == exp_dst, cur_req, "final dst ptr", {16'd0, dst_out}, {16'd0, exp_dst});
    end
  end

  task automatic run_op(input logic [1:0] m, input logic [15:0] s, input logic [15:0] d,
                        input logic [7:0] c, input logic [7:0] k, input string req);
    automatic int n = int'(c) + 1;
    automatic logic [15:0] p = s;
    cur_req = req;
    case (m)
      2'd0: begin
        for (int i = 0; i < n; i++) setb(d + 16'(i), getb(s + 16'(i)));
        exp_exit = 2'd1; exp_src = s + 16'(n); exp_dst = d + 16'(n);
      end
      2'd1: begin
        for (int i = 0; i < n; i++) setb(d - 16'(i), getb(s - 16'(i)));
        exp_exit = 2'd1; exp_src = s - 16'(n); exp_dst = d - 16'(n);
      end
      2'd2: begin
        for (int i = 0; i < 400; i++) begin
          if (getb(p) == k) break;
          setb(p, getb(d + 16'(getb(p))));
          p = p + 16'd1;
        end
        exp_exit = 2'd2; exp_src = p; exp_dst = d;
      end
      default: begin
        exp_exit = 2'd0; exp_src = s; exp_dst = d;
      end
    endcase
    done_seen = 1'b0;
    @(negedge clk);
    mode = m; src_ptr = s; dst_ptr = d; count = c; key = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy || done, "R8", "busy after start", {31'd0, busy}, 32'd1);
    if (m == 2'd3) chk(done == 1'b1, "R9", "no-op done next cycle", {31'd0, done}, 32'd1);
    for (int t = 0; t < 1200 && !done_seen; t++) @(posedge clk);
    if (!done_seen) chk(1'b0, req, "watchdog: no done", 32'd0, 32'd1);
    @(negedge clk);
    chk(!done && !busy, "R8", "one-cycle done, idle after", {30'd0, done, busy}, 32'd0);
    chk(exp_q.size() == 0, req, "writes outstanding", exp_q.size(), 32'd0);
    exp_q.delete();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      sh[i]  = 16'(i * 16'h9e37 + 16'h1234);
      mem[i] = sh[i];
    end
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && exit_code == 2'd0, "R1", "reset state",
        {28'd0, busy, done, mem_req, 1'b0}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req, "R1", "idle after reset", {30'd0, busy, mem_req}, 32'd0);

    run_op(2'd0, 16'd10,  16'd101, 8'd6,   8'd0, "R2");   // odd destination alignment
    run_op(2'd0, 16'd3,   16'd200, 8'd0,   8'd0, "R4");   // single character
    run_op(2'd1, 16'd300, 16'd151, 8'd9,   8'd0, "R3");   // reverse
    run_op(2'd1, 16'd41,  16'd40,  8'd3,   8'd0, "R3");   // reverse, same word pairs
    run_op(2'd0, 16'd0,   16'd256, 8'd255, 8'd0, "R4");   // 256 characters
    run_op(2'd2, 16'd40,  16'd300, 8'd0,   getb(16'd46), "R6");
    run_op(2'd2, 16'd77,  16'd120, 8'd0,   getb(16'd77), "R7"); // key first
    run_op(2'd2, 16'd201, 16'd0,   8'd0,   getb(16'd210), "R7");
    run_op(2'd3, 16'd55,  16'd66,  8'd9,   8'd0, "R9");

    for (int i = 0; i < 256; i++)
      if (mem[i] != sh[i]) chk(1'b0, "R5", $sformatf("final word %0d", i), {16'd0, mem[i]}, {16'd0, sh[i]});
    n_run++;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule